// File: doc/BRIEF.md
# Shared-Memory Command Ring Reader

This block sits on the device side of a command channel. The channel is a ring of 32-bit words kept in a memory that both a producer (host software) and this block can reach. The ring describes itself. Its lower bound, its upper bound, the producer's write position and the consumer's read position are all kept in the first four words of the same memory, as byte offsets. The producer appends words and moves its write position forward. The block reads the words that lie between its read position and the producer's position. It hands each word to a downstream command port and then stores its new read position back into memory. When a position reaches the upper bound it wraps to the lower bound.

Software gates the reader with a configuration-complete level. Software can also raise a one-cycle sync request. After a sync request the busy output stays high until the reader finds the ring empty. The block does not interpret the words it forwards. It has one memory port. A read returns data one cycle after it is requested. The port never stalls.

The downstream port uses valid/ready. While the port is valid and not ready, the block holds the word and keeps valid asserted. A word counts as delivered only in a cycle where valid and ready are both high. The downstream side may hold ready low for as long as it needs; no words are lost.

Top module: `cmd_ring_reader`

## Requirements
- R1: Memory words 0, 1, 2 and 3 hold the ring lower bound, the ring upper bound, the producer position and the consumer position. Each is a byte offset from the start of the memory. A ring word at byte offset P is accessed at word address P/4.
- R2: When the producer position equals the consumer position, the ring is empty. No word is offered and the stored consumer position stays unchanged.
- R3: Words are offered in ring order, starting at the consumer position and ending just before the producer position.
- R4: When the consumer position advances by 4 and the result equals the upper bound, the position becomes the lower bound. A ring with the producer position one word behind the consumer position is full and drains completely.
- R5: While cfg_done is 0, no new fetch sequence starts. When cfg_done returns to 1, draining resumes.
- R6: The consumer position in memory (word 3) is written only in the cycle after a word has been accepted. The value written is the advanced position.
- R7: Once cmd_valid is 1, it stays 1 and cmd_data stays unchanged until a cycle in which cmd_ready is 1.
- R8: A sync_req pulse sets busy to 1 in the next cycle. busy returns to 0 only after the reader has found the ring empty. While cfg_done is 0, busy stays 1.
- R9: The producer position is read again from memory before every word is fetched. Words the producer appends while a drain is in progress are therefore delivered in the same drain.
- R10: After reset, busy, cmd_valid, mem_rd and mem_wr are all 0.
- R11: Memory writes go only to word address 3. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Ring configured; permits fetching |
| sync_req | input | 1 | One-cycle sync request |
| busy | output | 1 | Sync outstanding; ring not yet seen empty |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid one cycle after mem_rd |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Downstream accepts the word |
| cmd_data | output | WORD_W | Command word |

## Verification
The assertions check these properties on every cycle:
- A held word stays stable under back-pressure.
- Each write-back goes to word 3, only after an acceptance, and with a value that lies inside the ring bounds.
- Reads and writes never overlap.
- No fetch starts while the gate is closed.
- A sync request always raises busy.

Only the bench scenarios can show the following:
- The words arrive in the right order, including across the wrap and in a full ring.
- The final stored position is correct.
- Words appended during a drain are picked up.
- busy stays high while the gate is closed and clears once the ring is empty.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_PROD,
    ST_RD_CONS,
    ST_CAPTURE,
    ST_FETCH,
    ST_LOAD,
    ST_OFFER,
    ST_WRITEBACK
  } seq_state_t;

  localparam int unsigned SLOT_LO   = 0;
  localparam int unsigned SLOT_HI   = 1;
  localparam int unsigned SLOT_PROD = 2;
  localparam int unsigned SLOT_CONS = 3;
endpackage

// File: rtl/ring_ptr_step.sv
module ring_ptr_step #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] prod,
  output logic [WORD_W-1:0] nxt,
  output logic              empty
);
  localparam int unsigned BPW = WORD_W / 8;

  logic [WORD_W-1:0] inc;

  always_comb begin
    inc   = cur + WORD_W'(BPW);
    nxt   = (inc == hi) ? lo : inc;
    empty = (prod == cur);
  end
endmodule

// File: rtl/ring_sync_busy.sv
module ring_sync_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_req,
  input  logic drained,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n)        busy <= 1'b0;
    else if (sync_req) busy <= 1'b1;
    else if (drained)  busy <= 1'b0;
  end

  assert_sync_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> busy);
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drained) |=> busy);
endmodule

// File: rtl/ring_fetch_seq.sv
module ring_fetch_seq
  import cmd_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_data,
  output logic              drained
);
  localparam int unsigned BPW   = WORD_W / 8;
  localparam int unsigned SHIFT = $clog2(BPW);

  seq_state_t        state;
  logic [WORD_W-1:0] lo_r, hi_r, prod_r, cons_r, data_r;
  logic [WORD_W-1:0] cons_adv;
  logic              ring_empty;

  ring_ptr_step #(.WORD_W(WORD_W)) u_step (
    .cur   (cons_r),
    .lo    (lo_r),
    .hi    (hi_r),
    .prod  (prod_r),
    .nxt   (cons_adv),
    .empty (ring_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lo_r   <= '0;
      hi_r   <= '0;
      prod_r <= '0;
      cons_r <= '0;
      data_r <= '0;
    end else begin
      unique case (state)
        ST_IDLE:      if (cfg_done) state <= ST_RD_LO;
        ST_RD_LO:     state <= ST_RD_HI;
        ST_RD_HI: begin
          lo_r  <= mem_rdata;
          state <= ST_RD_PROD;
        end
        ST_RD_PROD: begin
          hi_r  <= mem_rdata;
          state <= ST_RD_CONS;
        end
        ST_RD_CONS: begin
          prod_r <= mem_rdata;
          state  <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          cons_r <= mem_rdata;
          state  <= ST_FETCH;
        end
        ST_FETCH:     state <= ring_empty ? ST_IDLE : ST_LOAD;
        ST_LOAD: begin
          data_r <= mem_rdata;
          state  <= ST_OFFER;
        end
        ST_OFFER: begin
          if (cmd_ready) begin
            cons_r <= cons_adv;
            state  <= ST_WRITEBACK;
          end
        end
        ST_WRITEBACK: state <= cfg_done ? ST_RD_LO : ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = cons_r;
    unique case (state)
      ST_RD_LO:   begin mem_rd = 1'b1; mem_addr = ADDR_W'(SLOT_LO);   end
      ST_RD_HI:   begin mem_rd = 1'b1; mem_addr = ADDR_W'(SLOT_HI);   end
      ST_RD_PROD: begin mem_rd = 1'b1; mem_addr = ADDR_W'(SLOT_PROD); end
      ST_RD_CONS: begin mem_rd = 1'b1; mem_addr = ADDR_W'(SLOT_CONS); end
      ST_FETCH: begin
        mem_rd   = !ring_empty;
        mem_addr = ADDR_W'(cons_r >> SHIFT);
      end
      ST_WRITEBACK: begin mem_wr = 1'b1; mem_addr = ADDR_W'(SLOT_CONS); end
      default: ;
    endcase
  end

  assign cmd_valid = (state == ST_OFFER);
  assign cmd_data  = data_r;
  assign drained   = (state == ST_FETCH) && ring_empty;

  assert_hold_under_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));
  assert_wb_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(cmd_valid && cmd_ready));
  assert_wr_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == ADDR_W'(SLOT_CONS)));
  assert_no_rd_wr_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_gate_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == ST_IDLE) && !$past(cfg_done)) |-> !mem_rd);
  assert_wrap_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(lo_r < hi_r && cons_r >= lo_r && cons_r < hi_r &&
                     cons_r[1:0] == 2'b00 && lo_r[1:0] == 2'b00 && hi_r[1:0] == 2'b00))
    |-> (mem_wdata >= lo_r && mem_wdata < hi_r));
endmodule

// File: rtl/cmd_ring_reader.sv
module cmd_ring_reader #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              sync_req,
  output logic              busy,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_data
);
  logic drained;

  ring_fetch_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .drained   (drained)
  );

  ring_sync_busy u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_req (sync_req),
    .drained  (drained),
    .busy     (busy)
  );
endmodule

// File: tb/tb_cmd_ring_reader.sv
module tb_cmd_ring_reader;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_done = 1'b0;
  logic          sync_req = 1'b0;
  logic          busy, mem_rd, mem_wr, cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, cmd_data;
  logic [31:0]   mem_rdata = '0;

  logic [31:0] mem [DEPTH];
  logic [31:0] got [$];
  int cyc = 0, n_checks = 0, n_fail = 0, rd_count = 0, bad_wr = 0;
  logic ready_en = 1'b1;
  int   ready_div = 1;

  always #10 clk = ~clk;

  cmd_ring_reader #(.ADDR_W(AW), .WORD_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .sync_req(sync_req), .busy(busy),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_wr) begin
      mem[mem_addr] = mem_wdata;
      if (mem_addr != AW'(3)) bad_wr = bad_wr + 1;
    end
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      rd_count = rd_count + 1;
    end
    if (cmd_valid && cmd_ready) got.push_back(cmd_data);
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  always @(negedge clk) cmd_ready = ready_en && ((cyc % ready_div) == 0);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cfg_done = 1'b0; sync_req = 1'b0; ready_en = 1'b1; ready_div = 1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got.delete();
  endtask

  task automatic set_ring(input int lo, input int hi, input int prod, input int cons);
    mem[0] = lo; mem[1] = hi; mem[2] = prod; mem[3] = cons;
  endtask

  task automatic sync_wait(input string req);
    @(negedge clk); sync_req = 1'b1;
    @(negedge clk); sync_req = 1'b0;
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk(req, {31'd0, busy}, 32'd0);
  endtask

  task automatic chk_seq(input string req, input logic [31:0] exp [$]);
    chk(req, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++) chk(req, got[i], exp[i]);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 0);
    chk("R10 cmd_valid", {31'd0, cmd_valid}, 0);
    chk("R10 mem_rd", {31'd0, mem_rd}, 0);
    chk("R10 mem_wr", {31'd0, mem_wr}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    set_ring(16, 16 + 10240, 28, 16);
    mem[4] = 32'hA000_0001; mem[5] = 32'hA000_0002; mem[6] = 32'hA000_0003;
    cfg_done = 1'b1;
    sync_wait("R3 drain");
    chk_seq("R3 order", '{32'hA000_0001, 32'hA000_0002, 32'hA000_0003});
    chk("R1 stored position", mem[3], 28);
  endtask

  task automatic t_empty();
    do_reset();
    set_ring(16, 48, 32, 32);
    cfg_done = 1'b1;
    repeat (60) @(negedge clk);
    chk("R2 no word", got.size(), 0);
    chk("R2 position kept", mem[3], 32);
  endtask

  task automatic t_wrap();
    do_reset();
    set_ring(16, 48, 20, 40);
    mem[10] = 32'hB0; mem[11] = 32'hB1; mem[4] = 32'hB2;
    cfg_done = 1'b1;
    sync_wait("R4 drain");
    chk_seq("R4 wrap order", '{32'hB0, 32'hB1, 32'hB2});
    chk("R4 final position", mem[3], 20);
  endtask

  task automatic t_full();
    logic [31:0] exp [$];
    do_reset();
    set_ring(16, 48, 20, 24);
    for (int i = 6; i < 12; i++) begin mem[i] = 32'hC00 + i; exp.push_back(32'hC00 + i); end
    mem[4] = 32'hC04; exp.push_back(32'hC04);
    cfg_done = 1'b1;
    sync_wait("R4 full drain");
    chk_seq("R4 full ring", exp);
    chk("R4 full final position", mem[3], 20);
  endtask

  task automatic t_gate();
    int rd0;
    do_reset();
    set_ring(16, 48, 24, 16);
    mem[4] = 32'hD0; mem[5] = 32'hD1;
    rd0 = rd_count;
    repeat (60) @(negedge clk);
    chk("R5 no read while gated", rd_count - rd0, 0);
    chk("R5 no word while gated", got.size(), 0);
    chk("R5 position untouched", mem[3], 16);
    cfg_done = 1'b1;
    sync_wait("R5 resume");
    chk_seq("R5 resumed", '{32'hD0, 32'hD1});
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    do_reset();
    ready_en = 1'b0;
    set_ring(16, 48, 24, 16);
    mem[4] = 32'hE0; mem[5] = 32'hE1;
    cfg_done = 1'b1;
    for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
    held = cmd_data;
    repeat (20) @(negedge clk);
    chk("R7 valid held", {31'd0, cmd_valid}, 1);
    chk("R7 data held", cmd_data, held);
    chk("R6 no writeback before accept", mem[3], 16);
    ready_en = 1'b1;
    sync_wait("R6 drain");
    chk_seq("R7 order", '{32'hE0, 32'hE1});
    chk("R6 stored position", mem[3], 24);
  endtask

  task automatic t_live();
    do_reset();
    ready_div = 4;
    set_ring(16, 16 + 10240, 24, 16);
    mem[4] = 32'hF0; mem[5] = 32'hF1;
    cfg_done = 1'b1;
    for (int i = 0; i < 500 && got.size() < 1; i++) @(negedge clk);
    mem[6] = 32'hF2; mem[7] = 32'hF3; mem[8] = 32'hF4;
    mem[2] = 36;
    sync_wait("R9 drain");
    chk_seq("R9 appended words", '{32'hF0, 32'hF1, 32'hF2, 32'hF3, 32'hF4});
    chk("R9 final position", mem[3], 36);
  endtask

  task automatic t_busy();
    do_reset();
    set_ring(16, 48, 20, 16);
    mem[4] = 32'h55;
    @(negedge clk); sync_req = 1'b1;
    @(negedge clk); sync_req = 1'b0;
    chk("R8 busy set", {31'd0, busy}, 1);
    repeat (100) @(negedge clk);
    chk("R8 busy held while gated", {31'd0, busy}, 1);
    cfg_done = 1'b1;
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    chk("R8 busy cleared", {31'd0, busy}, 0);
    chk_seq("R8 drained", '{32'h55});
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    t_reset();
    t_basic();
    t_empty();
    t_wrap();
    t_full();
    t_gate();
    t_backpressure();
    t_live();
    t_busy();
    chk("R11 writes only to word 3", bad_wr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule